// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the 16x oversampling enable tick for a serial receiver and transmitter from the system clock. Software programs a divisor made of a 16-bit integer part and a 6-bit fraction in units of 1/64. The divisor equals the clock frequency divided by sixteen times the baud rate, so the 22-bit combined value is four times the clock frequency divided by the baud rate. The output is a one-cycle pulse whose average spacing equals that divisor.

The integer and fraction are written into shadow registers. They reach the divider only when the line-control register is written; the data of that write does not matter to this block. Software is expected to clear the UART enable before it changes the divisor and to set it again afterwards. While the enable is low, the divider holds its counter and its fraction accumulator at zero. When the enable rises, the divider restarts from the committed divisor.

The fraction is spread with a 6-bit accumulator. At the start of each period the fraction is added to the accumulator. A carry out of that sum makes the period one clock longer than the integer part. An integer part of zero is invalid and stops the tick. The finite-state machine has three states. OFF means the enable is low. STALL means the enable is high but the committed integer is zero. RUN means the divider is producing ticks. The transitions are OFF to RUN and OFF to STALL on enable (chosen by divisor validity), STALL to RUN on a valid commit, STALL to OFF and RUN to OFF on disable, and RUN to STALL when a zero integer is committed.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both shadow and both committed divisor values are zero and no tick is produced, even with the enable high.
- R2: With a committed fraction of zero and integer N (N ≥ 1), ticks are single-cycle pulses spaced exactly N cycles apart; N = 1 gives a tick on every cycle.
- R3: A write to offset 0x24 (integer, data bits 15:0) or 0x28 (fraction, data bits 5:0) changes only the shadow value. Both committed values take the shadow values on the clock edge of a write to offset 0x2C, whatever that write's data.
- R4: While the enable is low, no tick is produced and the accumulator is zero. The first period after the enable rises is measured from the first clock edge that samples the enable high. It lasts N plus the carry of (0 + fraction), counted in negative edges until the tick.
- R5: Each period lasts N cycles plus the carry out of the 6-bit sum of the accumulator and the committed fraction; the accumulator then keeps the low 6 bits. Any 64 consecutive periods last 64·N + fraction cycles.
- R6: While the committed integer is zero, no tick is produced.
- R7: Reading offset 0x24 returns the shadow integer, and reading offset 0x28 returns the shadow fraction in bits 5:0 with zeros above. Any other read offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| uart_en | input | 1 | UART enable; low holds the divider idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 16 | Register read data (combinational) |
| baud_tick16 | output | 1 | 16x oversampling tick, one cycle wide |

## Verification
The bench uses the default parameters: a 16-bit integer, a 6-bit fraction and 12-bit offsets. At these values the full 64-period accumulator cycle is short enough to measure whole. Integer one is reachable, both with no fraction and with a fraction of 63, so back-to-back ticks and the stretched-every-period case are both exercised. A behavioural model that tracks the committed divisor, the remaining count and the accumulator is compared with the tick on every cycle. This comparison covers disable, restart and a commit of a zero integer while running.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_STALL = 2'd1,
        ST_RUN   = 2'd2
    } bg_state_e;

    localparam int unsigned OFS_INT  = 'h24;
    localparam int unsigned OFS_FRAC = 'h28;
    localparam int unsigned OFS_LINE = 'h2C;
endpackage

// File: rtl/bg_shadow_regs.sv
module bg_shadow_regs #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int INT_W    = 16,
    parameter int FRAC_W   = 6,
    parameter int INT_OFF  = 'h24,
    parameter int FRAC_OFF = 'h28,
    parameter int LINE_OFF = 'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [INT_W-1:0]  shad_int,
    output logic [INT_W-1:0]  live_int,
    output logic [FRAC_W-1:0] live_frac
);
    localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(INT_OFF);
    localparam logic [ADDR_W-1:0] A_FRAC = ADDR_W'(FRAC_OFF);
    localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(LINE_OFF);

    logic [FRAC_W-1:0] shad_frac;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shad_int  <= '0;
            shad_frac <= '0;
            live_int  <= '0;
            live_frac <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_INT)  shad_int  <= wr_data[INT_W-1:0];
            if (wr_addr == A_FRAC) shad_frac <= wr_data[FRAC_W-1:0];
            if (wr_addr == A_LINE) begin
                live_int  <= shad_int;
                live_frac <= shad_frac;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_INT)
            rd_data[INT_W-1:0] = shad_int;
        else if (rd_addr == A_FRAC)
            rd_data[FRAC_W-1:0] = shad_frac;
    end
endmodule

// File: rtl/bg_frac_step.sv
module bg_frac_step #(
    parameter int FRAC_W = 6
) (
    input  logic [FRAC_W-1:0] acc,
    input  logic [FRAC_W-1:0] frac,
    output logic [FRAC_W-1:0] acc_next,
    output logic              carry
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum      = {1'b0, acc} + {1'b0, frac};
        acc_next = sum[FRAC_W-1:0];
        carry    = sum[FRAC_W];
    end
endmodule

// File: rtl/bg_tick_fsm.sv
module bg_tick_fsm
    import baud_gen_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_en,
    input  logic [INT_W-1:0]  live_int,
    input  logic [FRAC_W-1:0] live_frac,
    output logic              tick
);
    bg_state_e         state, state_nxt;
    logic [INT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc, acc_next;
    logic              carry, valid, reload;
    logic [INT_W:0]    len_full;

    bg_frac_step #(.FRAC_W(FRAC_W)) u_step (
        .acc      (acc),
        .frac     (live_frac),
        .acc_next (acc_next),
        .carry    (carry)
    );

    assign valid    = (live_int != '0);
    assign len_full = {1'b0, live_int} + {{INT_W{1'b0}}, carry} - 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   if (uart_en) state_nxt = valid ? ST_RUN : ST_STALL;
            ST_STALL: if (!uart_en) state_nxt = ST_OFF;
                      else if (valid) state_nxt = ST_RUN;
            ST_RUN:   if (!uart_en) state_nxt = ST_OFF;
                      else if (!valid) state_nxt = ST_STALL;
            default:  state_nxt = ST_OFF;
        endcase
    end

    assign reload = (state_nxt == ST_RUN) && ((state != ST_RUN) || (cnt == '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
        end else if (state_nxt != ST_RUN) begin
            cnt <= '0;
            acc <= '0;
        end else if (reload) begin
            cnt <= len_full[INT_W-1:0];
            acc <= acc_next;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        tick = (state == ST_RUN) && (cnt == '0) && uart_en && valid;
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int INT_W    = 16,
    parameter int FRAC_W   = 6,
    parameter int INT_OFF  = OFS_INT,
    parameter int FRAC_OFF = OFS_FRAC,
    parameter int LINE_OFF = OFS_LINE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              baud_tick16
);
    logic [INT_W-1:0]  shad_int;
    logic [INT_W-1:0]  live_int;
    logic [FRAC_W-1:0] live_frac;

    bg_shadow_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W),
        .INT_OFF(INT_OFF), .FRAC_OFF(FRAC_OFF), .LINE_OFF(LINE_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .shad_int  (shad_int),
        .live_int  (live_int),
        .live_frac (live_frac)
    );

    bg_tick_fsm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .uart_en   (uart_en),
        .live_int  (live_int),
        .live_frac (live_frac),
        .tick      (baud_tick16)
    );
endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
    parameter int ADDR_W   = 12,
    parameter int INT_W    = 16,
    parameter int INT_OFF  = 'h24,
    parameter int LINE_OFF = 'h2C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              uart_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              tick,
    input logic [INT_W-1:0]  shad_int,
    input logic [INT_W-1:0]  live_int
);
    AST_INT_WRITE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(INT_OFF)) |=> $stable(live_int)); // R3

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(LINE_OFF)) |=> (live_int == $past(shad_int))); // R3

    AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(uart_en)); // R4

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick)) |-> ($past(live_int) == INT_W'(1))); // R2

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ($past(live_int) != '0)); // R6
endmodule

bind baud_tick_gen bg_checker #(
    .ADDR_W(ADDR_W), .INT_W(INT_W), .INT_OFF(INT_OFF), .LINE_OFF(LINE_OFF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .uart_en  (uart_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .tick     (baud_tick16),
    .shad_int (shad_int),
    .live_int (live_int)
);

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uart_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        baud_tick16;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_sint = 0, m_sfrac = 0, m_cint = 0, m_cfrac = 0;
    int m_rem = 0, m_acc = 0;
    bit m_on = 0;

    always #5 clk = ~clk;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .baud_tick16(baud_tick16)
    );

    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            m_sint = 0; m_sfrac = 0; m_cint = 0; m_cfrac = 0;
            m_on = 0; m_rem = 0; m_acc = 0;
        end else begin
            if (!uart_en || m_cint == 0) begin
                m_on = 0; m_rem = 0; m_acc = 0;
            end else if (!m_on || m_rem == 0) begin
                s = m_acc + m_cfrac;
                m_rem = m_cint + ((s >= 64) ? 1 : 0) - 1;
                m_acc = s % 64;
                m_on = 1;
            end else begin
                m_rem = m_rem - 1;
            end
            if (wr_en) begin
                if (wr_addr == 12'h024) m_sint = int'(wr_data);
                if (wr_addr == 12'h028) m_sfrac = int'(wr_data) % 64;
                if (wr_addr == 12'h02C) begin m_cint = m_sint; m_cfrac = m_sfrac; end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !done)
            check(cur_req, int'(baud_tick16),
                  int'(m_on && m_rem == 0 && uart_en && m_cint != 0), "per-cycle tick");
    end

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input int exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(req, int'(rd_data), exp, "readback");
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (baud_tick16) n++;
        end
    endtask

    task automatic measure(input int periods, output int cyc);
        int k;
        do @(negedge clk); while (!baud_tick16);
        cyc = 0; k = 0;
        while (k < periods) begin
            @(negedge clk);
            cyc++;
            if (baud_tick16) k++;
        end
    endtask

    task automatic wrap_up;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            wrap_up();
        end
    end

    initial begin
        int n, cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        rd_check("R1", 12'h024, 0);
        rd_check("R1", 12'h028, 0);
        uart_en = 1'b1;
        count_ticks(20, n);
        check("R1", n, 0, "ticks after reset with enable");
        // R3: pending writes
        cur_req = "R3";
        wr(12'h024, 16'd5);
        count_ticks(20, n);
        check("R3", n, 0, "ticks before commit");
        rd_check("R7", 12'h024, 5);
        // R2: commit and exact spacing
        cur_req = "R2";
        wr(12'h02C, 16'h1234);
        measure(10, cyc);
        check("R2", cyc, 50, "10 periods of N=5");
        // R5: fractional spreading
        cur_req = "R5";
        uart_en = 1'b0;
        wr(12'h028, 16'hFFEB);
        rd_check("R7", 12'h028, 16'h002B);
        rd_check("R7", 12'h02C, 0);
        wr(12'h02C, 16'h0000);
        @(negedge clk); uart_en = 1'b1;
        measure(64, cyc);
        check("R5", cyc, 64*5 + 43, "64 periods N=5 f=43");
        // R2: integer one
        cur_req = "R2";
        uart_en = 1'b0;
        wr(12'h024, 16'd1);
        wr(12'h028, 16'd0);
        wr(12'h02C, 16'd0);
        @(negedge clk); uart_en = 1'b1;
        @(negedge clk);
        count_ticks(20, n);
        check("R2", n, 20, "N=1 ticks every cycle");
        // R5: integer one with full fraction
        cur_req = "R5";
        uart_en = 1'b0;
        wr(12'h028, 16'd63);
        wr(12'h02C, 16'd0);
        @(negedge clk); uart_en = 1'b1;
        measure(64, cyc);
        check("R5", cyc, 64 + 63, "64 periods N=1 f=63");
        // R4: disable and restart
        cur_req = "R4";
        uart_en = 1'b0;
        wr(12'h024, 16'd3);
        wr(12'h028, 16'd32);
        wr(12'h02C, 16'd0);
        count_ticks(15, n);
        check("R4", n, 0, "ticks while disabled");
        @(negedge clk); uart_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!baud_tick16 && n < 50);
        check("R4", n, 3, "first period after enable");
        measure(64, cyc);
        check("R5", cyc, 64*3 + 32, "64 periods N=3 f=32");
        // larger divisor
        cur_req = "R2";
        uart_en = 1'b0;
        wr(12'h024, 16'd300);
        wr(12'h028, 16'd0);
        wr(12'h02C, 16'd0);
        @(negedge clk); uart_en = 1'b1;
        measure(3, cyc);
        check("R2", cyc, 900, "3 periods N=300");
        // R6: zero integer committed while enabled
        cur_req = "R6";
        wr(12'h024, 16'd0);
        wr(12'h02C, 16'd0);
        @(negedge clk);
        count_ticks(400, n);
        check("R6", n, 0, "ticks with zero integer");
        rd_check("R7", 12'h024, 0);
        repeat (3) @(negedge clk);
        wrap_up();
    end
endmodule